// File: doc/BRIEF.md
# Reshapeable 18-Kilobit Block Memory

This block is a synchronous on-chip memory of fixed size, 18,432 bits. A parameter sets each port to one of six width/depth shapes. The three byte-oriented shapes also reach one extra bit per data byte, which the user can treat as parity. The other three shapes reach only the 16,384 data bits.

A second parameter chooses a single port or two ports. The two ports may use different shapes. A word written through a wide port can then be read back as several narrow words, or the other way round. Both ports share one clock.

Reads and writes are taken on the rising clock edge. Data-out is registered, so a read gives its result one cycle later. During a write, the port returns the contents the location held before the write.

Top module: `bram_ar_top`

## Requirements
- R1: Legal port widths are 1, 2, 4, 9, 18 and 36. The depth is 16384 divided by the data width, where the data width is W for W of 1, 2 or 4, and 8·W/9 otherwise. So the depths are 16K, 8K, 4K, 2K, 1K and 512. The address width is log2 of the depth, and the highest address reaches the last data bits of the array.
- R2: When a port's enable is high on a rising edge, its data-out takes the contents at the sampled address at that edge. The value is visible one cycle after the address is presented.
- R3: When a port's enable is low, its data-out holds its value and no write takes place, whatever the write-enable, address and data-in are.
- R4: On an enabled write, data-out shows the contents the location held before that write (read-first).
- R5: For widths of 9, 18 and 36, bits [DW-1:0] of data-in and data-out carry data bytes. Bit DW+j carries the extra bit of byte j. All of these bits are stored and returned.
- R6: Each data bit k of word a on a port with data width DW lives at flat data bit a·DW+k. Narrow words therefore fill a wide word from its least significant end (little-endian).
- R7: The extra bits cannot be seen through ports of width 1, 2 or 4. Writes through those ports leave the extra bits unchanged.
- R8: An active-low asynchronous reset clears both data-out registers to zero. It does not clear the array contents.
- R9: With two ports, both ports can read or write in the same cycle at different locations, and each gets its own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Asynchronous active-low reset of the output registers |
| ena_i | input | 1 | Port A enable |
| wea_i | input | 1 | Port A write enable |
| addra_i | input | AWA | Port A word address |
| dina_i | input | A_WIDTH | Port A write data |
| douta_o | output | A_WIDTH | Port A registered read data |
| enb_i | input | 1 | Port B enable (ignored in single-port build) |
| web_i | input | 1 | Port B write enable |
| addrb_i | input | AWB | Port B word address |
| dinb_i | input | B_WIDTH | Port B write data |
| doutb_o | output | B_WIDTH | Port B read data, zero in single-port build |

## Verification
The bench builds the block with two ports: port A at width 36 (512 words with four extra bits each) and port B at width 4 (4K nibbles). This pairing links one wide word to eight narrow words, so the little-endian mapping can be checked directly. Narrow writes can be shown to leave the extra bits untouched. The first and last addresses of both ports land on the same array bits. Read-first behaviour is checked from both sides, and so are concurrent use of the two ports and a reset that leaves the array intact.

// File: rtl/bram_ar_pkg.sv
package bram_ar_pkg;
  localparam int unsigned DATA_BITS  = 16384;
  localparam int unsigned BYTE_COUNT = DATA_BITS / 8;
  localparam int unsigned BYTE_AW    = $clog2(BYTE_COUNT);
  localparam int unsigned BIT_AW     = $clog2(DATA_BITS);

  function automatic bit legal_w(int unsigned w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18) || (w == 36);
  endfunction

  // data bits per word
  function automatic int unsigned data_w(int unsigned w);
    return (w % 9 == 0) ? (w / 9) * 8 : w;
  endfunction

  // extra (parity) bits per word
  function automatic int unsigned par_w(int unsigned w);
    return (w % 9 == 0) ? w / 9 : 0;
  endfunction

  function automatic int unsigned addr_w(int unsigned w);
    return $clog2(DATA_BITS / data_w(w));
  endfunction
endpackage

// File: rtl/bram_rd_port.sv
module bram_rd_port
  import bram_ar_pkg::*;
#(
  parameter int unsigned W = 36,
  localparam int unsigned AW = addr_w(W)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [7:0]            mem_i [BYTE_COUNT],
  input  logic [BYTE_COUNT-1:0] par_i,
  output logic [W-1:0]          dout_o
);
  localparam int unsigned DW = data_w(W);
  localparam int unsigned PW = par_w(W);
  localparam int unsigned BPW = (DW >= 8) ? DW / 8 : 1;

  logic [W-1:0] word_d;
  logic [W-1:0] dout_q;

  always_comb begin
    word_d = '0;
    for (int k = 0; k < int'(DW); k++) begin
      logic [BIT_AW-1:0] bi;
      bi = BIT_AW'(int'(addr_i) * int'(DW) + k);
      word_d[k] = mem_i[bi[BIT_AW-1:3]][bi[2:0]];
    end
    for (int j = 0; j < int'(PW); j++) begin
      logic [BYTE_AW-1:0] pi;
      pi = BYTE_AW'(int'(addr_i) * int'(BPW) + j);
      word_d[int'(DW) + j] = par_i[pi];
    end
  end

  // read-first: captures array before same-edge write lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dout_q <= '0;
    else if (en_i) dout_q <= word_d;
  end

  assign dout_o = dout_q;
endmodule

// File: rtl/bram_ar_top.sv
module bram_ar_top
  import bram_ar_pkg::*;
#(
  parameter int unsigned A_WIDTH   = 36,
  parameter int unsigned B_WIDTH   = 4,
  parameter bit          DUAL_PORT = 1'b1,
  localparam int unsigned AWA = addr_w(A_WIDTH),
  localparam int unsigned AWB = addr_w(B_WIDTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ena_i,
  input  logic               wea_i,
  input  logic [AWA-1:0]     addra_i,
  input  logic [A_WIDTH-1:0] dina_i,
  output logic [A_WIDTH-1:0] douta_o,
  input  logic               enb_i,
  input  logic               web_i,
  input  logic [AWB-1:0]     addrb_i,
  input  logic [B_WIDTH-1:0] dinb_i,
  output logic [B_WIDTH-1:0] doutb_o
);
  localparam int unsigned DWA  = data_w(A_WIDTH);
  localparam int unsigned PWA  = par_w(A_WIDTH);
  localparam int unsigned BPWA = (DWA >= 8) ? DWA / 8 : 1;
  localparam int unsigned DWB  = data_w(B_WIDTH);
  localparam int unsigned PWB  = par_w(B_WIDTH);
  localparam int unsigned BPWB = (DWB >= 8) ? DWB / 8 : 1;

  if (!legal_w(A_WIDTH) || !legal_w(B_WIDTH)) begin : g_bad_width
    $error("bram_ar_top: illegal port width");
  end

  logic [7:0]            mem_q [BYTE_COUNT];
  logic [BYTE_COUNT-1:0] par_q;

  logic wr_a, wr_b;
  assign wr_a = ena_i && wea_i;
  assign wr_b = DUAL_PORT && enb_i && web_i;

  // both ports in one process; same-bit collisions are undefined
  always_ff @(posedge clk_i) begin
    if (wr_a) begin
      for (int k = 0; k < int'(DWA); k++) begin
        logic [BIT_AW-1:0] bi;
        bi = BIT_AW'(int'(addra_i) * int'(DWA) + k);
        mem_q[bi[BIT_AW-1:3]][bi[2:0]] <= dina_i[k];
      end
      for (int j = 0; j < int'(PWA); j++) begin
        logic [BYTE_AW-1:0] pi;
        pi = BYTE_AW'(int'(addra_i) * int'(BPWA) + j);
        par_q[pi] <= dina_i[int'(DWA) + j];
      end
    end
    if (wr_b) begin
      for (int k = 0; k < int'(DWB); k++) begin
        logic [BIT_AW-1:0] bi;
        bi = BIT_AW'(int'(addrb_i) * int'(DWB) + k);
        mem_q[bi[BIT_AW-1:3]][bi[2:0]] <= dinb_i[k];
      end
      for (int j = 0; j < int'(PWB); j++) begin
        logic [BYTE_AW-1:0] pi;
        pi = BYTE_AW'(int'(addrb_i) * int'(BPWB) + j);
        par_q[pi] <= dinb_i[int'(DWB) + j];
      end
    end
  end

  bram_rd_port #(.W(A_WIDTH)) u_rd_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ena_i),
    .addr_i (addra_i),
    .mem_i  (mem_q),
    .par_i  (par_q),
    .dout_o (douta_o)
  );

  if (DUAL_PORT) begin : g_port_b
    bram_rd_port #(.W(B_WIDTH)) u_rd_b (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (enb_i),
      .addr_i (addrb_i),
      .mem_i  (mem_q),
      .par_i  (par_q),
      .dout_o (doutb_o)
    );
  end else begin : g_no_port_b
    assign doutb_o = '0;
  end
endmodule

// File: rtl/bram_ar_chk.sv
module bram_ar_chk
  import bram_ar_pkg::*;
#(
  parameter int unsigned A_WIDTH   = 36,
  parameter int unsigned B_WIDTH   = 4,
  parameter bit          DUAL_PORT = 1'b1,
  localparam int unsigned AWA = addr_w(A_WIDTH),
  localparam int unsigned AWB = addr_w(B_WIDTH)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ena_i,
  input logic               wea_i,
  input logic [AWA-1:0]     addra_i,
  input logic [A_WIDTH-1:0] dina_i,
  input logic [A_WIDTH-1:0] douta_o,
  input logic               enb_i,
  input logic               web_i,
  input logic [AWB-1:0]     addrb_i,
  input logic [B_WIDTH-1:0] dinb_i,
  input logic [B_WIDTH-1:0] doutb_o
);
  // R3
  a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ena_i |=> $stable(douta_o));

  // R3
  b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enb_i |=> $stable(doutb_o));

  // R2
  a_write_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ena_i && wea_i) && ena_i && !wea_i && addra_i == $past(addra_i))
    |=> douta_o == $past(dina_i, 2));

  // R2
  b_write_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DUAL_PORT && $past(enb_i && web_i) && enb_i && !web_i && addrb_i == $past(addrb_i))
    |=> doutb_o == $past(dinb_i, 2));

  // R8
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (douta_o == '0 && doutb_o == '0));
endmodule

bind bram_ar_top bram_ar_chk #(
  .A_WIDTH  (A_WIDTH),
  .B_WIDTH  (B_WIDTH),
  .DUAL_PORT(DUAL_PORT)
) u_chk (.*);

// File: tb/sim_bram_ar_top.sv
module sim_bram_ar_top;
  localparam int unsigned AW_A = 9;
  localparam int unsigned AW_B = 12;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            ena = 1'b0, wea = 1'b0, enb = 1'b0, web = 1'b0;
  logic [AW_A-1:0] addra = '0;
  logic [AW_B-1:0] addrb = '0;
  logic [35:0]     dina = '0;
  logic [3:0]      dinb = '0;
  logic [35:0]     douta;
  logic [3:0]      doutb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bram_ar_top #(.A_WIDTH(36), .B_WIDTH(4), .DUAL_PORT(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .ena_i(ena), .wea_i(wea), .addra_i(addra), .dina_i(dina), .douta_o(douta),
    .enb_i(enb), .web_i(web), .addrb_i(addrb), .dinb_i(dinb), .doutb_o(doutb)
  );

  // {addr[8:0], word[35:0]}; word[35:32] = extra bits
  localparam logic [44:0] VEC [8] = '{
    {9'd0,   36'h9_1234_5678},
    {9'd1,   36'h3_89AB_CDEF},
    {9'd2,   36'hF_FFFF_FFFF},
    {9'd3,   36'hA_0F0F_0F0F},
    {9'd4,   36'h5_DEAD_BEEF},
    {9'd5,   36'h6_CAFE_F00D},
    {9'd255, 36'h1_0000_0001},
    {9'd511, 36'hC_8765_4321}
  };

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next one (after the rising edge)
  task automatic op(input logic ea, input logic wa, input logic [AW_A-1:0] aa,
                    input logic [35:0] da, input logic eb, input logic wb,
                    input logic [AW_B-1:0] ab, input logic [3:0] db);
    ena = ea; wea = wa; addra = aa; dina = da;
    enb = eb; web = wb; addrb = ab; dinb = db;
    @(negedge clk);
  endtask

  task automatic idle();
    op(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset douta", douta, 36'h0);
    chk("R8 reset doutb", {32'h0, doutb}, 36'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R5 R6: table walk, wide write then wide and narrow read-back
    for (int i = 0; i < 8; i++)
      op(1'b1, 1'b1, VEC[i][44:36], VEC[i][35:0], 1'b0, 1'b0, '0, '0);
    for (int i = 0; i < 8; i++) begin
      op(1'b1, 1'b0, VEC[i][44:36], '0, 1'b0, 1'b0, '0, '0);
      chk("R2 R5 wide read", douta, VEC[i][35:0]);
      for (int n = 0; n < 8; n++) begin
        op(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, AW_B'(int'(VEC[i][44:36]) * 8 + n), '0);
        chk("R6 narrow read", {32'h0, doutb}, {32'h0, VEC[i][4*n +: 4]});
      end
    end

    // R1: last narrow address is top nibble of last wide word
    op(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 12'd4095, '0);
    chk("R1 last narrow addr", {32'h0, doutb}, 36'h8);

    // R4: wide write returns old contents
    op(1'b1, 1'b1, 9'd5, 36'h0_1111_2222, 1'b0, 1'b0, '0, '0);
    chk("R4 read-first A", douta, 36'h6_CAFE_F00D);
    op(1'b1, 1'b0, 9'd5, '0, 1'b0, 1'b0, '0, '0);
    chk("R2 after write", douta, 36'h0_1111_2222);

    // R3: disabled write leaves output and array alone
    op(1'b0, 1'b1, 9'd5, 36'hF_FFFF_FFFF, 1'b0, 1'b1, 12'd40, 4'hF);
    chk("R3 output held", douta, 36'h0_1111_2222);
    op(1'b1, 1'b0, 9'd5, '0, 1'b1, 1'b0, 12'd40, '0);
    chk("R3 no write A", douta, 36'h0_1111_2222);
    chk("R3 no write B", {32'h0, doutb}, 36'h2);

    // R7 R4: narrow write into word 3 nibble 2
    op(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, 12'd26, 4'h6);
    chk("R4 read-first B", {32'h0, doutb}, 36'hF);
    op(1'b1, 1'b0, 9'd3, '0, 1'b0, 1'b0, '0, '0);
    chk("R7 extra bits kept", douta, 36'hA_0F0F_060F);

    // R9: concurrent ports on distinct locations
    op(1'b1, 1'b1, 9'd100, 36'h7_7777_7777, 1'b1, 1'b0, 12'd0, '0);
    chk("R9 concurrent B read", {32'h0, doutb}, 36'h8);
    op(1'b1, 1'b0, 9'd100, '0, 1'b1, 1'b1, 12'd9, 4'h4);
    chk("R9 concurrent A read", douta, 36'h7_7777_7777);
    chk("R9 concurrent B write old", {32'h0, doutb}, 36'hE);
    op(1'b1, 1'b0, 9'd1, '0, 1'b1, 1'b0, 12'd803, '0);
    chk("R9 B write seen by A", douta, 36'h3_89AB_CD4F);
    chk("R9 A write seen by B", {32'h0, doutb}, 36'h7);

    // R8: reset clears outputs only
    idle();
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R8 mid reset douta", douta, 36'h0);
    chk("R8 mid reset doutb", {32'h0, doutb}, 36'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    op(1'b1, 1'b0, 9'd511, '0, 1'b1, 1'b0, 12'd0, '0);
    chk("R8 array kept A", douta, 36'hC_8765_4321);
    chk("R1 first narrow addr", {32'h0, doutb}, 36'h8);
    idle();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule